// File: doc/BRIEF.md
# Variable Page Size Two-Level Data TLB

This block translates 64-bit virtual addresses into physical addresses for data accesses. It keeps two fully associative translation stores. A small first level is searched first. A larger second level is searched only when the first level misses. Every entry records a virtual page tag, a physical frame and a 4-bit page size code, so each entry matches under its own mask. Pages range from 4 KB to 256 MB.

A lookup that hits in the first level answers in one cycle. A lookup that hits only in the second level answers one cycle later and copies the entry into the first level. When both levels miss, the block raises a request to an external page walker and holds it until the walker answers. The walker's translation is written into both levels and returned to the requester. A purge command names an aligned range of up to 4 GB and removes every entry whose page overlaps that range.

The lookup channel and the purge channel use ready/valid handshakes. Both stall while a lookup, walk or purge is in flight.

Top module: `pgtlb`

## Requirements
- R1: While reset is held, and at the first clock after it is released, `req_ready` is 1, `rsp_valid` is 0 and `walk_req_valid` is 0. `purge_ready` is 1 when `req_valid` is 0.
- R2: Size codes 0 to 9 select page shifts 12, 13, 14, 16, 18, 20, 22, 24, 26 and 28 (4 KB up to 256 MB). Codes 10 to 15 behave as code 0 (4 KB).
- R3: The response address takes the bits below the page shift from the virtual address. It takes the bits at and above the page shift from the entry's frame, which is given in 4 KB units. Frame bits below the page shift are ignored.
- R4: An entry matches when all virtual address bits from the page shift up to bit 63 equal its tag. An address one page size above an entry's base does not match that entry.
- R5: A first-level hit raises `rsp_valid` for exactly one cycle, with `rsp_level` = 1, on the clock after the one that accepts the lookup.
- R6: A lookup that misses the first level and hits the second returns `rsp_level` = 2 one cycle later than a first-level hit. It also copies the entry into the first level, so a repeat lookup returns level 1.
- R7: A miss in both levels drives `walk_req_valid` with `walk_req_va` equal to the looked-up address. Both are held until `walk_rsp_valid`. The response then carries `rsp_level` = 3 and an address formed from the returned frame and size. The translation is installed in both levels.
- R8: First-level victims are chosen round-robin. After N1+1 distinct installs, the oldest page is gone from the first level but is still found in the second level. The second level keeps its own round-robin pointer.
- R9: Installing a page into a level first invalidates every entry of that level whose page overlaps it. No address ever hits more than one entry in a level.
- R10: A purge of base B and span code S invalidates, in both levels, every entry whose page overlaps the 2^S-byte region containing B. S is clamped to the range 12 to 32. Entries outside the region stay valid.
- R11: `req_ready` is 0 from the clock that accepts a lookup or purge until the block is idle again. `purge_ready` is 0 while busy and whenever `req_valid` is 1, so a lookup takes precedence over a purge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Block can accept a lookup |
| req_va | input | VA_W | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_pa | output | PA_W | Translated physical address |
| rsp_level | output | 2 | Level that answered: 1 first, 2 second, 3 walker |
| purge_valid | input | 1 | Purge request valid |
| purge_ready | output | 1 | Block can accept a purge |
| purge_va | input | VA_W | Any address inside the purge region |
| purge_span | input | 6 | Log2 of the purge region size in bytes |
| walk_req_valid | output | 1 | Walk request, held until answered |
| walk_req_va | output | VA_W | Address the walker must translate |
| walk_rsp_valid | input | 1 | Walker answer strobe |
| walk_rsp_frame | input | PA_W-12 | Physical frame in 4 KB units |
| walk_rsp_size | input | 4 | Page size code of the returned translation |

## Verification
The bench builds the block with a 4-entry first level and a 6-entry second level and keeps the 64-bit virtual and 48-bit physical widths. The small first level lets a fifth install push the oldest page out after a handful of walks, so the second-level refill path and round-robin victim choice can be observed directly. Full-width addresses are still needed to show that bit 63 takes part in the match. The full 4 GB purge clears all low test addresses between scenarios, and each size code is then checked at the inner and outer edge of its page.

// File: rtl/pgtlb_pkg.sv
package pgtlb_pkg;
  localparam int GRAN = 12;
  localparam logic [5:0] GRAN6 = 6'd12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1,
    ST_L2,
    ST_WALK,
    ST_PURGE
  } tlb_state_t;

  localparam logic [1:0] LVL_FIRST  = 2'd1;
  localparam logic [1:0] LVL_SECOND = 2'd2;
  localparam logic [1:0] LVL_WALKER = 2'd3;

  // page shift in address bits for a 4-bit size code
  function automatic logic [5:0] size_shift(input logic [3:0] code);
    case (code)
      4'd0: return 6'd12;
      4'd1: return 6'd13;
      4'd2: return 6'd14;
      4'd3: return 6'd16;
      4'd4: return 6'd18;
      4'd5: return 6'd20;
      4'd6: return 6'd22;
      4'd7: return 6'd24;
      4'd8: return 6'd26;
      4'd9: return 6'd28;
      default: return 6'd12;
    endcase
  endfunction

  // purge region size is held between 4 KB and 4 GB
  function automatic logic [5:0] clamp_span(input logic [5:0] s);
    if (s < 6'd12) return 6'd12;
    if (s > 6'd32) return 6'd32;
    return s;
  endfunction
endpackage

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int N = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [IW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (adv) begin
      if (ptr == IW'(N - 1)) ptr <= '0;
      else                   ptr <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_bank.sv
module tlb_bank
  import pgtlb_pkg::*;
#(
  parameter int N  = 32,
  parameter int TW = 52,
  parameter int FW = 36
) (
  input  logic          clk,
  input  logic          rst,
  // associative search
  input  logic [TW-1:0] lk_tag,
  output logic [N-1:0]  hit_vec,
  output logic          hit,
  output logic [FW-1:0] hit_frame,
  output logic [3:0]    hit_sz,
  // overlap invalidation
  input  logic          kill_en,
  input  logic [TW-1:0] kill_tag,
  input  logic [5:0]    kill_shift,
  // install at the round-robin slot
  input  logic          wr_en,
  input  logic [TW-1:0] wr_tag,
  input  logic [FW-1:0] wr_frame,
  input  logic [3:0]    wr_sz
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  vld;
  logic [N-1:0]  kill_vec;
  logic [TW-1:0] tag_mem   [N];
  logic [FW-1:0] frame_mem [N];
  logic [3:0]    sz_mem    [N];
  logic [IW-1:0] vptr;

  tlb_rr_ptr #(.N(N)) u_ptr (
    .clk (clk),
    .rst (rst),
    .adv (wr_en),
    .ptr (vptr)
  );

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic [5:0]    esh;
    logic [TW-1:0] emask;
    logic [TW-1:0] kmask;
    assign esh   = size_shift(sz_mem[i]);
    assign emask = {TW{1'b1}} << (esh - GRAN6);
    // compare above the larger of the two boundaries
    assign kmask = (esh > kill_shift) ? emask
                                      : ({TW{1'b1}} << (kill_shift - GRAN6));
    assign hit_vec[i]  = vld[i] && (((tag_mem[i] ^ lk_tag) & emask) == '0);
    assign kill_vec[i] = vld[i] && (((tag_mem[i] ^ kill_tag) & kmask) == '0);
  end

  // at most one entry hits, so an OR tree selects it
  always_comb begin
    hit_frame = '0;
    hit_sz    = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) begin
        hit_frame = hit_frame | frame_mem[i];
        hit_sz    = hit_sz | sz_mem[i];
      end
    end
  end
  assign hit = |hit_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else begin
      if (kill_en) vld <= vld & ~kill_vec;
      if (wr_en)   vld[vptr] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[vptr]   <= wr_tag;
      frame_mem[vptr] <= wr_frame;
      sz_mem[vptr]    <= wr_sz;
    end
  end
endmodule

// File: rtl/pgtlb.sv
module pgtlb
  import pgtlb_pkg::*;
#(
  parameter int VA_W = 64,
  parameter int PA_W = 48,
  parameter int L1_N = 32,
  parameter int L2_N = 96,
  localparam int FW = PA_W - GRAN,
  localparam int TW = VA_W - GRAN
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_va,
  output logic            rsp_valid,
  output logic [PA_W-1:0] rsp_pa,
  output logic [1:0]      rsp_level,
  input  logic            purge_valid,
  output logic            purge_ready,
  input  logic [VA_W-1:0] purge_va,
  input  logic [5:0]      purge_span,
  output logic            walk_req_valid,
  output logic [VA_W-1:0] walk_req_va,
  input  logic            walk_rsp_valid,
  input  logic [FW-1:0]   walk_rsp_frame,
  input  logic [3:0]      walk_rsp_size
);
  tlb_state_t      st;
  logic [VA_W-1:0] va_q;
  logic [5:0]      span_q;

  logic [L1_N-1:0] l1_hitv;
  logic [L2_N-1:0] l2_hitv;
  logic            l1_hit, l2_hit;
  logic [FW-1:0]   l1_frame, l2_frame;
  logic [3:0]      l1_sz, l2_sz;

  logic            l1_kill, l2_kill, l1_wr, l2_wr;
  logic [5:0]      kill_sh;
  logic [FW-1:0]   wr_frame;
  logic [3:0]      wr_sz;

  function automatic logic [PA_W-1:0] pa_of(input logic [PA_W-1:0] vlow,
                                            input logic [FW-1:0]   fr,
                                            input logic [3:0]      sz);
    logic [PA_W-1:0] lowm;
    lowm = ~({PA_W{1'b1}} << size_shift(sz));
    return ({fr, {GRAN{1'b0}}} & ~lowm) | (vlow & lowm);
  endfunction

  assign req_ready   = (st == ST_IDLE);
  assign purge_ready = (st == ST_IDLE) && !req_valid;

  // install and invalidate controls for both levels
  always_comb begin
    l1_kill  = 1'b0;
    l2_kill  = 1'b0;
    l1_wr    = 1'b0;
    l2_wr    = 1'b0;
    kill_sh  = span_q;
    wr_frame = walk_rsp_frame;
    wr_sz    = walk_rsp_size;
    case (st)
      ST_L2: if (l2_hit) begin
        l1_kill  = 1'b1;
        l1_wr    = 1'b1;
        kill_sh  = size_shift(l2_sz);
        wr_frame = l2_frame;
        wr_sz    = l2_sz;
      end
      ST_WALK: if (walk_rsp_valid) begin
        l1_kill = 1'b1;
        l2_kill = 1'b1;
        l1_wr   = 1'b1;
        l2_wr   = 1'b1;
        kill_sh = size_shift(walk_rsp_size);
      end
      ST_PURGE: begin
        l1_kill = 1'b1;
        l2_kill = 1'b1;
      end
      default: ;
    endcase
  end

  tlb_bank #(.N(L1_N), .TW(TW), .FW(FW)) u_l1 (
    .clk        (clk),
    .rst        (rst),
    .lk_tag     (va_q[VA_W-1:GRAN]),
    .hit_vec    (l1_hitv),
    .hit        (l1_hit),
    .hit_frame  (l1_frame),
    .hit_sz     (l1_sz),
    .kill_en    (l1_kill),
    .kill_tag   (va_q[VA_W-1:GRAN]),
    .kill_shift (kill_sh),
    .wr_en      (l1_wr),
    .wr_tag     (va_q[VA_W-1:GRAN]),
    .wr_frame   (wr_frame),
    .wr_sz      (wr_sz)
  );

  tlb_bank #(.N(L2_N), .TW(TW), .FW(FW)) u_l2 (
    .clk        (clk),
    .rst        (rst),
    .lk_tag     (va_q[VA_W-1:GRAN]),
    .hit_vec    (l2_hitv),
    .hit        (l2_hit),
    .hit_frame  (l2_frame),
    .hit_sz     (l2_sz),
    .kill_en    (l2_kill),
    .kill_tag   (va_q[VA_W-1:GRAN]),
    .kill_shift (kill_sh),
    .wr_en      (l2_wr),
    .wr_tag     (va_q[VA_W-1:GRAN]),
    .wr_frame   (walk_rsp_frame),
    .wr_sz      (walk_rsp_size)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= ST_IDLE;
      va_q           <= '0;
      span_q         <= 6'd12;
      rsp_valid      <= 1'b0;
      rsp_pa         <= '0;
      rsp_level      <= '0;
      walk_req_valid <= 1'b0;
      walk_req_va    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            va_q <= req_va;
            st   <= ST_L1;
          end else if (purge_valid) begin
            va_q   <= purge_va;
            span_q <= clamp_span(purge_span);
            st     <= ST_PURGE;
          end
        end
        ST_L1: begin
          if (l1_hit) begin
            rsp_valid <= 1'b1;
            rsp_pa    <= pa_of(va_q[PA_W-1:0], l1_frame, l1_sz);
            rsp_level <= LVL_FIRST;
            st        <= ST_IDLE;
          end else begin
            st <= ST_L2;
          end
        end
        ST_L2: begin
          if (l2_hit) begin
            rsp_valid <= 1'b1;
            rsp_pa    <= pa_of(va_q[PA_W-1:0], l2_frame, l2_sz);
            rsp_level <= LVL_SECOND;
            st        <= ST_IDLE;
          end else begin
            walk_req_valid <= 1'b1;
            walk_req_va    <= va_q;
            st             <= ST_WALK;
          end
        end
        ST_WALK: begin
          if (walk_rsp_valid) begin
            walk_req_valid <= 1'b0;
            rsp_valid      <= 1'b1;
            rsp_pa         <= pa_of(va_q[PA_W-1:0], walk_rsp_frame, walk_rsp_size);
            rsp_level      <= LVL_WALKER;
            st             <= ST_IDLE;
          end
        end
        ST_PURGE: st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgtlb_chk.sv
module pgtlb_chk #(
  parameter int N1   = 32,
  parameter int N2   = 96,
  parameter int VA_W = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic [1:0]      rsp_level,
  input logic            purge_valid,
  input logic            purge_ready,
  input logic            walk_req_valid,
  input logic [VA_W-1:0] walk_req_va,
  input logic            walk_rsp_valid,
  input logic [N1-1:0]   l1_hitv,
  input logic [N2-1:0]   l2_hitv
);
  // R9
  l1_unique_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(l1_hitv));
  // R9
  l2_unique_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(l2_hitv));
  // R11
  walk_stall_chk: assert property (@(posedge clk) disable iff (rst)
    walk_req_valid |-> !req_ready);
  // R7
  walk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    walk_req_valid && !walk_rsp_valid |=> walk_req_valid);
  // R7
  walk_va_chk: assert property (@(posedge clk) disable iff (rst)
    walk_req_valid && !walk_rsp_valid |=> $stable(walk_req_va));
  // R5
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  // R5
  rsp_level_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_level != 2'd0);
  // R11
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready);
  // R11
  purge_busy_chk: assert property (@(posedge clk) disable iff (rst)
    purge_valid && purge_ready |=> !req_ready && !purge_ready);
  // R11
  lookup_first_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !purge_ready);
endmodule

bind pgtlb pgtlb_chk #(.N1(L1_N), .N2(L2_N), .VA_W(VA_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .rsp_valid      (rsp_valid),
  .rsp_level      (rsp_level),
  .purge_valid    (purge_valid),
  .purge_ready    (purge_ready),
  .walk_req_valid (walk_req_valid),
  .walk_req_va    (walk_req_va),
  .walk_rsp_valid (walk_rsp_valid),
  .l1_hitv        (l1_hitv),
  .l2_hitv        (l2_hitv)
);

// File: tb/pgtlb_test.sv
module pgtlb_test;
  localparam int VA_W = 64;
  localparam int PA_W = 48;
  localparam int FW   = PA_W - 12;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [VA_W-1:0] req_va = '0;
  logic            rsp_valid;
  logic [PA_W-1:0] rsp_pa;
  logic [1:0]      rsp_level;
  logic            purge_valid = 1'b0;
  logic            purge_ready;
  logic [VA_W-1:0] purge_va = '0;
  logic [5:0]      purge_span = '0;
  logic            walk_req_valid;
  logic [VA_W-1:0] walk_req_va;
  logic            walk_rsp_valid = 1'b0;
  logic [FW-1:0]   walk_rsp_frame = '0;
  logic [3:0]      walk_rsp_size = '0;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  logic [FW-1:0] wk_frame;
  logic [3:0]    wk_size;

  pgtlb #(.VA_W(VA_W), .PA_W(PA_W), .L1_N(4), .L2_N(6)) uut (
    .clk (clk), .rst (rst),
    .req_valid (req_valid), .req_ready (req_ready), .req_va (req_va),
    .rsp_valid (rsp_valid), .rsp_pa (rsp_pa), .rsp_level (rsp_level),
    .purge_valid (purge_valid), .purge_ready (purge_ready),
    .purge_va (purge_va), .purge_span (purge_span),
    .walk_req_valid (walk_req_valid), .walk_req_va (walk_req_va),
    .walk_rsp_valid (walk_rsp_valid), .walk_rsp_frame (walk_rsp_frame),
    .walk_rsp_size (walk_rsp_size)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL R11 watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int exp_shift(input logic [3:0] c);
    int t[10] = '{12, 13, 14, 16, 18, 20, 22, 24, 26, 28};
    if (c > 4'd9) return 12;
    return t[c];
  endfunction

  function automatic logic [PA_W-1:0] exp_pa(input logic [63:0] va, input logic [FW-1:0] fr,
                                             input logic [3:0] c);
    logic [63:0] base, low;
    low  = (64'd1 << exp_shift(c)) - 64'd1;
    base = {16'd0, fr, 12'd0};
    return PA_W'((base & ~low) | (va & low));
  endfunction

  // issue one lookup; acts as the walker if asked
  task automatic lookup(input logic [63:0] va, output logic [PA_W-1:0] pa,
                        output logic [1:0] lvl, output int waits);
    bit walked = 0;
    req_va = va;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    waits = 0;
    while (!rsp_valid && waits < 64) begin
      if (walk_req_valid && !walked) begin
        chk("R7 walk address", walk_req_va, va);
        chk("R11 stall during walk", {63'd0, req_ready}, 64'd0);
        walk_rsp_valid = 1'b1;
        walk_rsp_frame = wk_frame;
        walk_rsp_size = wk_size;
        walked = 1;
      end
      @(negedge clk);
      walk_rsp_valid = 1'b0;
      waits = waits + 1;
    end
    pa = rsp_pa;
    lvl = rsp_level;
  endtask

  task automatic purge(input logic [63:0] base, input logic [5:0] span);
    purge_va = base;
    purge_span = span;
    purge_valid = 1'b1;
    while (!purge_ready) @(negedge clk);
    @(negedge clk);
    purge_valid = 1'b0;
    chk("R11 stall during purge", {62'd0, req_ready, purge_ready}, 64'd0);
    @(negedge clk);
  endtask

  task automatic expect_lookup(input string tag, input logic [63:0] va,
                               input logic [1:0] elvl, input logic [PA_W-1:0] epa);
    logic [PA_W-1:0] pa;
    logic [1:0] lvl;
    int w;
    lookup(va, pa, lvl, w);
    chk({tag, " level"}, {62'd0, lvl}, {62'd0, elvl});
    chk({tag, " address"}, {16'd0, pa}, {16'd0, epa});
    if (elvl == 2'd1) chk("R5 first-level latency", w, 1);
    if (elvl == 2'd2) chk("R6 second-level latency", w, 2);
  endtask

  task automatic t_reset();
    chk("R1 ready in reset", {61'd0, req_ready, purge_ready, rsp_valid}, 64'd6);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", {61'd0, req_ready, rsp_valid, walk_req_valid}, 64'd4);
  endtask

  task automatic t_sizes();
    for (int k = 0; k < 11; k++) begin
      logic [3:0] c;
      logic [63:0] a, step;
      c = (k == 10) ? 4'd12 : 4'(k);
      a = 64'h3000_0000;
      step = 64'd1 << exp_shift(c);
      purge(64'd0, 6'd32);
      wk_frame = 36'h00FED_C345;
      wk_size = c;
      expect_lookup("R2 walk fill", a + 64'h18, 2'd3, exp_pa(a + 64'h18, wk_frame, c));
      expect_lookup("R3 inner edge", a + step - 64'd8, 2'd1, exp_pa(a + step - 64'd8, 36'h00FED_C345, c));
      wk_frame = 36'h777;
      wk_size = 4'd0;
      expect_lookup("R4 outer edge", a + step, 2'd3, exp_pa(a + step, 36'h777, 4'd0));
    end
  endtask

  task automatic t_refill();
    purge(64'd0, 6'd32);
    wk_size = 4'd0;
    for (int p = 1; p <= 5; p++) begin
      wk_frame = FW'(p * 16 + 1);
      expect_lookup("R7 install", 64'(p) << 16, 2'd3, exp_pa(64'(p) << 16, FW'(p * 16 + 1), 4'd0));
    end
    expect_lookup("R8 oldest in second level", 64'h1_0abc, 2'd2, 48'h11abc);
    expect_lookup("R6 refilled to first level", 64'h1_0abc, 2'd1, 48'h11abc);
    expect_lookup("R8 newest kept", 64'h5_0004, 2'd1, 48'h51004);
  endtask

  task automatic t_overlap();
    purge(64'd0, 6'd32);
    wk_frame = 36'h111;
    wk_size = 4'd0;
    expect_lookup("R9 small page", 64'h50_3000, 2'd3, 48'h111000);
    wk_frame = 36'h22200;
    wk_size = 4'd5;
    expect_lookup("R9 covering page", 64'h50_7010, 2'd3, 48'h2220_7010);
    expect_lookup("R9 old page replaced", 64'h50_3044, 2'd1, 48'h2220_3044);
  endtask

  task automatic t_purge();
    purge(64'd0, 6'd32);
    wk_size = 4'd0;
    wk_frame = 36'h0AA;
    expect_lookup("R10 fill one", 64'h10_0000, 2'd3, 48'hAA000);
    wk_frame = 36'h0BB;
    expect_lookup("R10 fill two", 64'h20_0000, 2'd3, 48'hBB000);
    purge(64'h10_0000, 6'd20);
    expect_lookup("R10 outside range kept", 64'h20_0008, 2'd1, 48'hBB008);
    wk_frame = 36'h0CC;
    expect_lookup("R10 inside range purged", 64'h10_0008, 2'd3, 48'hCC008);
    purge(64'h20_0800, 6'd3);
    wk_frame = 36'h0DD;
    expect_lookup("R10 span clamp", 64'h20_0010, 2'd3, 48'hDD010);
  endtask

  task automatic t_priority();
    req_va = 64'h10_0000;
    req_valid = 1'b1;
    purge_valid = 1'b1;
    #1;
    chk("R11 lookup over purge", {62'd0, req_ready, purge_ready}, 64'd2);
    req_valid = 1'b0;
    purge_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_high_bits();
    wk_frame = 36'h3C3;
    wk_size = 4'd0;
    expect_lookup("R4 high address fill", 64'h8000_0000_0000_1000, 2'd3, 48'h3C3000);
    wk_frame = 36'h5A5;
    expect_lookup("R4 bit 63 compared", 64'h0000_0000_0000_1000, 2'd3, 48'h5A5000);
    expect_lookup("R4 high address kept", 64'h8000_0000_0000_1004, 2'd1, 48'h3C3004);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_sizes();
    t_refill();
    t_overlap();
    t_purge();
    t_priority();
    t_high_bits();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule